// File: doc/BRIEF.md
# Software Step Controller

This block is the single-step logic of a small in-order core. It keeps three bits of state. The step enable is written through the debug control word. The live step flag and the debug mask bit are loaded only from the status word that an exception return restores. From these bits and an external debug-allowed qualifier it classifies the step machine into one of three states. Those states are INACTIVE, ARMED (active, not pending) and PENDING (active, pending).

In ARMED the core may issue until one instruction retires. Retirement clears the live flag, which moves the machine to PENDING. It raises no exception at that point. In PENDING, issue is blocked and a step exception request is raised. The request is taken at once unless an interrupt is pending or another exception is entering in the same cycle; in those cases the interrupt goes first.

On every exception entry, whether a step exception or any other, the block presents the flag and mask values to be saved with the status word. It then clears the live flag and sets the mask. When the core returns with a saved flag of 0, the machine lands straight in PENDING. The step exception is then taken without a second instruction executing. This keeps executing the stepped instruction apart from reporting its completion.

Top module: `sstep_ctrl`

States and transitions:
- INACTIVE to ARMED or PENDING: the enable is 1, the mask is 0, debug is allowed, and the flag selects which of the two.
- ARMED to PENDING: an instruction retires.
- PENDING to INACTIVE: the step exception is taken, or any other exception enters (the mask is set).
- Any state to INACTIVE: the enable is written to 0 or debug is disallowed.
- Any state to ARMED or PENDING: an exception return loads a flag and a mask of 0.

## Requirements
- R1: A write on the control port loads the step enable from bit 0 of the written word and ignores all other bits. The enable resets to 0.
- R2: With the enable at 0, the mask bit at 1, or debug disallowed, the state is INACTIVE (step_state 0). In INACTIVE, issue_ok is 1, step_exc_req is 0, step_exc_take is 0, and a retire leaves the flag unchanged.
- R3: When active with the flag at 1, the state is ARMED (step_state 1), issue_ok is 1 and no request is raised. A retire clears the flag, and the state is PENDING after that edge, with no exception taken while ARMED.
- R4: When active with the flag at 0, the state is PENDING (step_state 2), issue_ok is 0 and step_exc_req is 1, however the flag came to be 0.
- R5: step_exc_take is 1 exactly when PENDING with irq_pending at 0 and exc_entry at 0. The request stays asserted for as long as the interrupt holds it off.
- R6: On an exception entry (exc_entry, or a taken step exception), held_ss takes the flag value after any retire in the same cycle and held_dm takes the mask. The live flag is cleared and the mask is set, so the state is INACTIVE after that edge.
- R7: On exc_return, the flag loads from ret_word bit 21 and the mask from ret_word bit 9. Entry takes priority over return in the same cycle, and no other path sets the flag.
- R8: After reset, step_state is 0, the flag is 0, the mask is 1, held_ss and held_dm are 0, and issue_ok is 1. Any state change shows on step_state after the edge that samples its cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr_en | input | 1 | Debug control word write strobe |
| ctl_wr_data | input | CTL_W | Debug control word; bit 0 is the step enable |
| dbg_allow | input | 1 | Debug exceptions permitted at the current level and security state |
| retire | input | 1 | One instruction retired this cycle |
| exc_entry | input | 1 | Another exception (e.g. interrupt) is being entered |
| exc_return | input | 1 | Exception return this cycle |
| ret_word | input | STAT_W | Status word restored by the return |
| irq_pending | input | 1 | Higher-priority interrupt pending |
| issue_ok | output | 1 | Core may issue an instruction |
| step_exc_req | output | 1 | Step exception requested |
| step_exc_take | output | 1 | Step exception taken this cycle |
| step_state | output | 2 | 0 INACTIVE, 1 ARMED, 2 PENDING |
| held_ss | output | 1 | Step flag value to save with the status word |
| held_dm | output | 1 | Mask value to save with the status word |

## Verification
A wrong flag or mask shows up on step_state, issue_ok and step_exc_req on the first cycle after the edge that corrupted it. A flag stuck at 1 lets a second instruction issue. A flag stuck at 0 fires an exception with nothing stepped. A lost or inverted saved flag appears on held_ss one edge after entry. After the following return it shows as ARMED where PENDING was due, so the missed exception is visible one cycle after that return. The priority fault, a step taken under a pending interrupt, shows on step_exc_take in the same cycle.

// File: rtl/sstep_pkg.sv
package sstep_pkg;

    typedef enum logic [1:0] {
        ST_INACTIVE = 2'd0,
        ST_ARMED    = 2'd1,
        ST_PENDING  = 2'd2
    } step_state_e;

    // Classification of the step machine from its qualifying bits.
    function automatic step_state_e classify(
        input logic en,
        input logic mask,
        input logic allow,
        input logic flag
    );
        if (!en || mask || !allow) begin
            return ST_INACTIVE;
        end
        return flag ? ST_ARMED : ST_PENDING;
    endfunction

endpackage

// File: rtl/sstep_ctl_reg.sv
module sstep_ctl_reg #(
    parameter int CTL_W  = 32,
    parameter int EN_BIT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    output logic             en_d,
    output logic             en_q
);
    localparam logic [CTL_W-1:0] EN_MASK = CTL_W'(1) << EN_BIT;

    // Only the enable bit is held; the rest of the word has no effect.
    logic unused_ctl_bits;
    assign unused_ctl_bits = ^(wr_data & ~EN_MASK);

    always_comb begin
        en_d = wr_en ? wr_data[EN_BIT] : en_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= en_d;
        end
    end
endmodule

// File: rtl/sstep_flags.sv
module sstep_flags #(
    parameter int STAT_W = 32,
    parameter int SS_BIT = 21,
    parameter int DM_BIT = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              armed,
    input  logic              retire,
    input  logic              exc_entry,
    input  logic              step_take,
    input  logic              exc_return,
    input  logic [STAT_W-1:0] ret_word,
    output logic              ss_d,
    output logic              dm_d,
    output logic              held_ss,
    output logic              held_dm
);
    localparam logic [STAT_W-1:0] USED_MASK =
        (STAT_W'(1) << SS_BIT) | (STAT_W'(1) << DM_BIT);

    logic unused_ret_bits;
    assign unused_ret_bits = ^(ret_word & ~USED_MASK);

    logic ss_q, dm_q;
    logic ss_after;   // flag once this cycle's retire is accounted for
    logic enter;

    always_comb begin
        enter    = exc_entry | step_take;
        ss_after = (armed && retire) ? 1'b0 : ss_q;
        if (enter) begin
            ss_d = 1'b0;
            dm_d = 1'b1;
        end else if (exc_return) begin
            ss_d = ret_word[SS_BIT];
            dm_d = ret_word[DM_BIT];
        end else begin
            ss_d = ss_after;
            dm_d = dm_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ss_q    <= 1'b0;
            dm_q    <= 1'b1;
            held_ss <= 1'b0;
            held_dm <= 1'b0;
        end else begin
            ss_q <= ss_d;
            dm_q <= dm_d;
            if (enter) begin
                held_ss <= ss_after;
                held_dm <= dm_q;
            end
        end
    end
endmodule

// File: rtl/sstep_fsm.sv
module sstep_fsm
    import sstep_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en_d,
    input  logic        dm_d,
    input  logic        ss_d,
    input  logic        dbg_allow,
    input  logic        irq_pending,
    input  logic        exc_entry,
    output step_state_e state_q,
    output logic        issue_ok,
    output logic        req,
    output logic        take
);
    step_state_e state_d;

    always_comb begin
        state_d = classify(en_d, dm_d, dbg_allow, ss_d);
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_INACTIVE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs.
    always_comb begin
        issue_ok = 1'b1;
        req      = 1'b0;
        take     = 1'b0;
        unique case (state_q)
            ST_INACTIVE: begin
                issue_ok = 1'b1;
            end
            ST_ARMED: begin
                issue_ok = 1'b1;
            end
            ST_PENDING: begin
                issue_ok = 1'b0;
                req      = 1'b1;
                take     = !irq_pending && !exc_entry;
            end
            default: begin
                issue_ok = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/sstep_ctrl.sv
module sstep_ctrl
    import sstep_pkg::*;
#(
    parameter int CTL_W  = 32,
    parameter int STAT_W = 32,
    parameter int EN_BIT = 0,
    parameter int SS_BIT = 21,
    parameter int DM_BIT = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr_en,
    input  logic [CTL_W-1:0]  ctl_wr_data,
    input  logic              dbg_allow,
    input  logic              retire,
    input  logic              exc_entry,
    input  logic              exc_return,
    input  logic [STAT_W-1:0] ret_word,
    input  logic              irq_pending,
    output logic              issue_ok,
    output logic              step_exc_req,
    output logic              step_exc_take,
    output logic [1:0]        step_state,
    output logic              held_ss,
    output logic              held_dm
);
    logic        en_d, en_q;
    logic        ss_d, dm_d;
    step_state_e state_q;

    logic unused_en_q;
    assign unused_en_q = en_q;

    sstep_ctl_reg #(.CTL_W(CTL_W), .EN_BIT(EN_BIT)) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctl_wr_en),
        .wr_data (ctl_wr_data),
        .en_d    (en_d),
        .en_q    (en_q)
    );

    sstep_flags #(.STAT_W(STAT_W), .SS_BIT(SS_BIT), .DM_BIT(DM_BIT)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .armed      (state_q == ST_ARMED),
        .retire     (retire),
        .exc_entry  (exc_entry),
        .step_take  (step_exc_take),
        .exc_return (exc_return),
        .ret_word   (ret_word),
        .ss_d       (ss_d),
        .dm_d       (dm_d),
        .held_ss    (held_ss),
        .held_dm    (held_dm)
    );

    sstep_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_d        (en_d),
        .dm_d        (dm_d),
        .ss_d        (ss_d),
        .dbg_allow   (dbg_allow),
        .irq_pending (irq_pending),
        .exc_entry   (exc_entry),
        .state_q     (state_q),
        .issue_ok    (issue_ok),
        .req         (step_exc_req),
        .take        (step_exc_take)
    );

    assign step_state = state_q;
endmodule

// File: rtl/sstep_ctrl_chk.sv
module sstep_ctrl_chk #(
    parameter int CTL_W  = 32,
    parameter int EN_BIT = 0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_wr_en,
    input logic [CTL_W-1:0] ctl_wr_data,
    input logic             dbg_allow,
    input logic             retire,
    input logic             exc_entry,
    input logic             exc_return,
    input logic             irq_pending,
    input logic             issue_ok,
    input logic             step_exc_req,
    input logic             step_exc_take,
    input logic [1:0]       step_state,
    input logic             held_ss
);
    // R1
    disable_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_en && !ctl_wr_data[EN_BIT] && !exc_return) |=> (step_state == 2'd0));

    // R2
    inactive_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_state == 2'd0) |-> (issue_ok && !step_exc_req && !step_exc_take));

    // R3
    armed_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_state == 2'd1 && retire && !exc_return) |=> (step_state != 2'd1));

    // R4
    pending_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_state == 2'd2) |-> (!issue_ok && step_exc_req));

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_state == 2'd2 && irq_pending && !exc_entry && !exc_return
         && !ctl_wr_en && dbg_allow) |=> (step_state == 2'd2 && step_exc_req));

    // R5
    irq_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pending || exc_entry) |-> !step_exc_take);

    // R6
    entry_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_entry |=> (step_state == 2'd0));

    // R6
    take_saves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_exc_take |=> (step_state == 2'd0 && !held_ss));

    // R7
    no_direct_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_state == 2'd2 && !exc_return) |=> (step_state != 2'd1));

    // R8
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_state != 2'd3);
endmodule

bind sstep_ctrl sstep_ctrl_chk #(.CTL_W(CTL_W), .EN_BIT(EN_BIT)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctl_wr_en     (ctl_wr_en),
    .ctl_wr_data   (ctl_wr_data),
    .dbg_allow     (dbg_allow),
    .retire        (retire),
    .exc_entry     (exc_entry),
    .exc_return    (exc_return),
    .irq_pending   (irq_pending),
    .issue_ok      (issue_ok),
    .step_exc_req  (step_exc_req),
    .step_exc_take (step_exc_take),
    .step_state    (step_state),
    .held_ss       (held_ss)
);

// File: tb/sstep_ctrl_bench.sv
module sstep_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr_en = 1'b0;
    logic [31:0] ctl_wr_data = '0;
    logic        dbg_allow = 1'b1;
    logic        retire = 1'b0;
    logic        exc_entry = 1'b0;
    logic        exc_return = 1'b0;
    logic [31:0] ret_word = '0;
    logic        irq_pending = 1'b0;
    logic        issue_ok, step_exc_req, step_exc_take, held_ss, held_dm;
    logic [1:0]  step_state;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    sstep_ctrl u_sstep_ctrl (
        .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
        .dbg_allow(dbg_allow), .retire(retire), .exc_entry(exc_entry),
        .exc_return(exc_return), .ret_word(ret_word), .irq_pending(irq_pending),
        .issue_ok(issue_ok), .step_exc_req(step_exc_req), .step_exc_take(step_exc_take),
        .step_state(step_state), .held_ss(held_ss), .held_dm(held_dm)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Outputs: state, issue, request, take
    task automatic chk_out(input string tag, input int st, input int iss,
                           input int rq, input int tk);
        chk({tag, " state"}, step_state, st);
        chk({tag, " issue_ok"}, issue_ok, iss);
        chk({tag, " req"}, step_exc_req, rq);
        chk({tag, " take"}, step_exc_take, tk);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        ctl_wr_en  = 1'b0;
        retire     = 1'b0;
        exc_entry  = 1'b0;
        exc_return = 1'b0;
    endtask

    task automatic write_ctl(input logic [31:0] d);
        ctl_wr_en = 1'b1;
        ctl_wr_data = d;
        tick();
    endtask

    // Return restoring flag (bit 21) and mask (bit 9)
    task automatic do_return(input logic ss, input logic dm);
        exc_return = 1'b1;
        ret_word = 32'hFFFF_FFFF;
        ret_word[21] = ss;
        ret_word[9] = dm;
        tick();
    endtask

    task automatic t_reset();
        chk_out("R8 reset", 0, 1, 0, 0);
        chk("R8 reset held_ss", held_ss, 0);
        chk("R8 reset held_dm", held_dm, 0);
        write_ctl(32'h1);
        chk("R8 mask set at reset", step_state, 0);
        write_ctl(32'h0);
    endtask

    task automatic t_pending_direct();
        do_return(1'b0, 1'b0);
        chk("R2 enable off", step_state, 0);
        write_ctl(32'hFFFF_FFFE);
        chk("R1 other bits ignored", step_state, 0);
        write_ctl(32'h1);
        chk_out("R4 pending without step", 2, 0, 1, 1);
        tick();
        chk_out("R6 after step take", 0, 1, 0, 0);
        chk("R6 held_ss after take", held_ss, 0);
        chk("R6 held_dm after take", held_dm, 0);
    endtask

    task automatic t_single_step();
        do_return(1'b1, 1'b0);
        chk_out("R3 armed", 1, 1, 0, 0);
        tick(); tick();
        chk_out("R3 armed until retire", 1, 1, 0, 0);
        retire = 1'b1;
        tick();
        chk_out("R3 retire to pending", 2, 0, 1, 1);
        tick();
        chk("R6 step taken", step_state, 0);
    endtask

    task automatic t_irq_mid_step();
        do_return(1'b1, 1'b0);
        irq_pending = 1'b1;
        retire = 1'b1;
        tick();
        chk_out("R5 irq holds off take", 2, 0, 1, 0);
        tick(); tick();
        chk_out("R5 request held", 2, 0, 1, 0);
        exc_entry = 1'b1;
        tick();
        irq_pending = 1'b0;
        chk("R6 irq entry inactive", step_state, 0);
        chk("R6 saved flag 0", held_ss, 0);
        chk("R6 saved mask 0", held_dm, 0);
        do_return(held_ss, held_dm);
        chk_out("R7 return to pending", 2, 0, 1, 1);
        tick();
        chk("R7 step taken after return", step_state, 0);
        // Interrupt before the stepped instruction retires
        do_return(1'b1, 1'b0);
        exc_entry = 1'b1;
        tick();
        chk("R6 saved flag 1", held_ss, 1);
        do_return(held_ss, held_dm);
        chk("R7 restored armed", step_state, 1);
        retire = 1'b1;
        exc_entry = 1'b1;
        tick();
        chk("R6 retire same cycle saves 0", held_ss, 0);
    endtask

    task automatic t_masked();
        do_return(1'b1, 1'b1);
        chk_out("R2 masked", 0, 1, 0, 0);
        retire = 1'b1;
        tick();
        chk_out("R2 masked retire", 0, 1, 0, 0);
        dbg_allow = 1'b0;
        do_return(1'b1, 1'b0);
        chk("R2 disallowed", step_state, 0);
        retire = 1'b1;
        tick();
        chk("R2 disallowed no take", step_exc_take, 0);
        dbg_allow = 1'b1;
        tick();
        chk("R2 flag kept across inactive retire", step_state, 1);
        retire = 1'b1;
        tick();
        tick();
        chk("R3 cleanup", step_state, 0);
    endtask

    task automatic t_toggle();
        write_ctl(32'h0);
        write_ctl(32'h1);
        chk("R1 toggle while inactive masked", step_state, 0);
        do_return(1'b1, 1'b0);
        write_ctl(32'h0);
        chk("R1 disable armed", step_state, 0);
        write_ctl(32'h1);
        chk("R1 re-enable armed", step_state, 1);
        irq_pending = 1'b1;
        retire = 1'b1;
        tick();
        write_ctl(32'h0);
        chk_out("R1 disable pending", 0, 1, 0, 0);
        write_ctl(32'h1);
        chk_out("R1 re-enable pending", 2, 0, 1, 0);
        irq_pending = 1'b0;
        #1;
        chk("R5 take when irq clears", step_exc_take, 1);
        tick();
        chk("R5 taken", step_state, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        #1;
        t_reset();
        t_pending_direct();
        t_single_step();
        t_irq_mid_step();
        t_masked();
        t_toggle();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule